// File: doc/BRIEF.md
# Inbound Message Post Queue

This block carries messages from a host bus to a local processor. A host master writes a 32-bit message frame address into a queue port. The block writes that address into a circular queue kept in local memory, at the queue base plus the current head offset. When the memory takes the write, the head moves one entry forward, a status bit is set and an interrupt is raised to the local processor.

The processor uses a small register bank to work the queue. It reads the head and tail pointers, clears the status bits by writing ones to them, and consumes entries by writing a new tail. The queue holds `QDEPTH` entries of 4 bytes each. One slot always stays empty, so a post that arrives while the queue is full is dropped and flagged.

Register word index on `reg_idx`: 0 is the base register, 1 is the head pointer, 2 is the tail pointer and 3 is the status register.

Top module: `msg_post_queue`

## Requirements
- R1: A port write taken while the queue is not full raises `mem_valid` on the next cycle. `mem_addr` is then {base[31:20], head*4 in bits 19:0} and `mem_data` is the written frame address.
- R2: `mem_valid`, `mem_addr` and `mem_data` hold steady until `mem_ready` is seen high. The head advances by one entry only on that handshake.
- R3: Every head advance sets status bit 0. `irq` is high exactly when status bit 0 is set and the head differs from the tail.
- R4: Status bits 0 and 1 are write-one-to-clear at index 3. Writing a 0 to a bit leaves it unchanged.
- R5: The tail changes only on a register write at index 2. It then takes the entry number from write bits [2 +: log2(QDEPTH)].
- R6: Reads of the head and tail pointer registers return base bits 31:20 in bits 31:20, the pointer as a byte offset in bits 19:2, and zero in bits 1:0. The base register keeps only write bits 31:20, and the other bits read as zero.
- R7: After reset, the base, head, tail and status all read 0, `irq` and `mem_valid` are low, and `port_ready` is high.
- R8: The pointers wrap modulo QDEPTH entries. The address after the last slot is the base again.
- R9: A port write while head+1 equals tail (modulo QDEPTH) makes no memory write, leaves the head unchanged and sets status bit 1.
- R10: `port_ready` is low while a store is outstanding. Port writes in that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_wr | input | 1 | Queue port write strobe |
| port_data | input | 32 | Message frame address to post |
| port_ready | output | 1 | High when a port write can be taken |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_idx) |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write byte address |
| mem_data | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| irq | output | 1 | Interrupt to the local processor |

## Verification
A port write shows on the memory port one clock edge later. The head, status and `irq` change on the edge where `mem_valid` meets `mem_ready`. Register writes show up in reads after their own edge, and reads are combinational. The bench drives and samples on falling edges. It checks the memory request on the first falling edge after the port strobe, on every stalled cycle, and again after the handshake edge, where it reads the head and status back. A dropped post is checked on the falling edge after its strobe: no request appears and the overflow bit is set.

// File: rtl/mpq_pkg.sv
package mpq_pkg;

    typedef enum logic [1:0] {
        RG_BASE = 2'd0,
        RG_HEAD = 2'd1,
        RG_TAIL = 2'd2,
        RG_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } store_state_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } store_req_t;

    // Builds the software view of a pointer: base high bits, then the word offset, then two zero bits.
    function automatic logic [31:0] ptr_view(input logic [11:0] base_hi, input logic [17:0] word_ofs);
        return {base_hi, word_ofs, 2'b00};
    endfunction

endpackage

// File: rtl/mpq_regs.sv
module mpq_regs
    import mpq_pkg::*;
#(
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  reg_sel_e        reg_sel,
    input  logic [31:0]     reg_wdata,
    input  logic [IDXW-1:0] head_idx,
    input  logic            adv,
    input  logic            ovf_set,
    output logic [11:0]     base_hi,
    output logic [IDXW-1:0] tail_idx,
    output logic            ist,
    output logic            ovf,
    output logic [31:0]     reg_rdata
);
    logic wr_base, wr_tail, wr_stat;
    logic unused_wbits;

    assign wr_base = reg_wr && (reg_sel == RG_BASE);
    assign wr_tail = reg_wr && (reg_sel == RG_TAIL);
    assign wr_stat = reg_wr && (reg_sel == RG_STAT);
    assign unused_wbits = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi  <= '0;
            tail_idx <= '0;
            ist      <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            if (wr_base) base_hi  <= reg_wdata[31:20];
            if (wr_tail) tail_idx <= reg_wdata[2 +: IDXW];
            // A new event in the same cycle wins over a clear.
            ist <= adv     | (ist & ~(wr_stat & reg_wdata[0]));
            ovf <= ovf_set | (ovf & ~(wr_stat & reg_wdata[1]));
        end
    end

    always_comb begin
        unique case (reg_sel)
            RG_BASE: reg_rdata = {base_hi, 20'h0};
            RG_HEAD: reg_rdata = ptr_view(base_hi, 18'(head_idx));
            RG_TAIL: reg_rdata = ptr_view(base_hi, 18'(tail_idx));
            default: reg_rdata = {30'h0, ovf, ist};
        endcase
    end

endmodule

// File: rtl/mpq_store.sv
module mpq_store
    import mpq_pkg::*;
#(
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            port_wr,
    input  logic [31:0]     port_data,
    input  logic [11:0]     base_hi,
    input  logic [IDXW-1:0] tail_idx,
    input  logic            mem_ready,
    output logic            port_ready,
    output logic            mem_valid,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_data,
    output logic [IDXW-1:0] head_idx,
    output logic            adv,
    output logic            ovf_set
);
    store_state_e    state_q;
    store_req_t      req_q;
    logic [IDXW-1:0] head_next;
    logic            full;
    logic            take;

    assign head_next  = head_idx + 1'b1;
    assign full       = (head_next == tail_idx);
    assign port_ready = (state_q == ST_IDLE);
    assign take       = port_ready && port_wr && !full;
    assign ovf_set    = port_ready && port_wr && full;
    assign mem_valid  = (state_q == ST_BUSY);
    assign adv        = mem_valid && mem_ready;
    assign mem_addr   = req_q.addr;
    assign mem_data   = req_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            req_q    <= '0;
            head_idx <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (take) begin
                    req_q.addr <= {base_hi, 20'(head_idx) << 2};
                    req_q.data <= port_data;
                    state_q    <= ST_BUSY;
                end
                default: if (mem_ready) begin
                    head_idx <= head_next;
                    state_q  <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/msg_post_queue.sv
module msg_post_queue
    import mpq_pkg::*;
#(
    parameter int QDEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        port_wr,
    input  logic [31:0] port_data,
    output logic        port_ready,
    input  logic        reg_wr,
    input  logic [1:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_valid,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_data,
    input  logic        mem_ready,
    output logic        irq
);
    localparam int IDXW = (QDEPTH > 2) ? $clog2(QDEPTH) : 1;

    logic [IDXW-1:0] head_idx, tail_idx;
    logic [11:0]     base_hi;
    logic            adv, ovf_set, ist_q, ovf_q;
    reg_sel_e        reg_sel;

    assign reg_sel = reg_sel_e'(reg_idx);

    mpq_store #(.IDXW(IDXW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .port_wr    (port_wr),
        .port_data  (port_data),
        .base_hi    (base_hi),
        .tail_idx   (tail_idx),
        .mem_ready  (mem_ready),
        .port_ready (port_ready),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .head_idx   (head_idx),
        .adv        (adv),
        .ovf_set    (ovf_set)
    );

    mpq_regs #(.IDXW(IDXW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .head_idx  (head_idx),
        .adv       (adv),
        .ovf_set   (ovf_set),
        .base_hi   (base_hi),
        .tail_idx  (tail_idx),
        .ist       (ist_q),
        .ovf       (ovf_q),
        .reg_rdata (reg_rdata)
    );

    assign irq = ist_q && (head_idx != tail_idx);

endmodule

// File: rtl/mpq_checker.sv
module mpq_checker #(
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            port_wr,
    input logic            port_ready,
    input logic            reg_wr,
    input logic [1:0]      reg_idx,
    input logic            mem_valid,
    input logic            mem_ready,
    input logic [31:0]     mem_addr,
    input logic [31:0]     mem_data,
    input logic [IDXW-1:0] head_idx,
    input logic [IDXW-1:0] tail_idx,
    input logic            ist_q,
    input logic            ovf_q,
    input logic            irq
);
    // R2: a stalled request holds its address and data
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R2: the head steps by one on a handshake
    a_r2_head_step: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready) |=> (head_idx == $past(head_idx) + 1'b1));

    // R2: the head holds when there is no handshake
    a_r2_head_hold: assert property (@(posedge clk) disable iff (rst)
        !(mem_valid && mem_ready) |=> $stable(head_idx));

    // R3: an advance sets the post status bit
    a_r3_status_set: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready) |=> ist_q);

    // R3: no interrupt without the status bit
    a_r3_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
        irq |-> ist_q);

    // R5: only a write to the tail register moves the tail
    a_r5_tail_only_sw: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_idx == 2'd2) |=> $stable(tail_idx));

    // R1: the memory address is word aligned
    a_r1_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    // R9: a post into a full queue sets the overflow bit
    a_r9_overflow: assert property (@(posedge clk) disable iff (rst)
        (port_wr && port_ready && (IDXW'(head_idx + 1'b1) == tail_idx)) |=> ovf_q);

    // R10: the port is not ready while a store is outstanding
    a_r10_busy_port: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !port_ready);

endmodule

bind msg_post_queue mpq_checker #(.IDXW(IDXW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .port_wr    (port_wr),
    .port_ready (port_ready),
    .reg_wr     (reg_wr),
    .reg_idx    (reg_idx),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .head_idx   (head_idx),
    .tail_idx   (tail_idx),
    .ist_q      (ist_q),
    .ovf_q      (ovf_q),
    .irq        (irq)
);

// File: tb/tb_msg_post_queue.sv
`timescale 1ns/1ps
module tb_msg_post_queue;

    localparam int QD = 8;
    localparam logic [31:0] BASE = 32'h1230_0000;
    // Each entry: stall cycles in [35:32], frame address in [31:0].
    localparam logic [35:0] VEC [7] = '{
        {4'd0, 32'hA000_0010}, {4'd2, 32'hA000_0020}, {4'd1, 32'hB0B0_0040},
        {4'd0, 32'hC000_0080}, {4'd3, 32'hDEAD_BEE0}, {4'd0, 32'h0000_0100},
        {4'd1, 32'hFFFF_FFFC}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_wr = 1'b0;
    logic [31:0] port_data = '0;
    logic        port_ready;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        mem_ready = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int exp_head = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    msg_post_queue #(.QDEPTH(QD)) dut (
        .clk(clk), .rst(rst), .port_wr(port_wr), .port_data(port_data),
        .port_ready(port_ready), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready), .irq(irq)
    );

    function automatic logic [31:0] ptr_exp(input logic [31:0] b, input int idx);
        return {b[31:20], 20'(idx * 4)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] i, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] i, output logic [31:0] v);
        @(negedge clk);
        reg_idx = i;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic post(input logic [31:0] d, input int stall, input logic [31:0] b);
        @(negedge clk);
        port_wr = 1'b1; port_data = d;
        @(negedge clk);
        port_wr = 1'b0;
        check("R1 valid", 32'(mem_valid), 32'd1);
        check("R1 addr", mem_addr, ptr_exp(b, exp_head));
        check("R1 data", mem_data, d);
        check("R10 port busy", 32'(port_ready), 32'd0);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check("R2 stall hold", {mem_addr[31:1], mem_valid}, {ptr_exp(b, exp_head) >> 1, 1'b1});
        end
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        check("R2 released", 32'(mem_valid), 32'd0);
        exp_head = (exp_head + 1) % QD;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7 reset state
        check("R7 irq", 32'(irq), 32'd0);
        check("R7 mem_valid", 32'(mem_valid), 32'd0);
        check("R7 port_ready", 32'(port_ready), 32'd1);
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), rv);
            check("R7 reg", rv, 32'd0);
        end
        // R6 base keeps only bits 31:20
        wr(2'd0, BASE | 32'h0000_0ABC);
        rd(2'd0, rv); check("R6 base", rv, BASE);
        rd(2'd1, rv); check("R6 head view", rv, ptr_exp(BASE, 0));

        // Table of posts: fills the queue to 7 entries
        for (int v = 0; v < 7; v++) begin
            post(VEC[v][31:0], int'(VEC[v][35:32]), BASE);
            rd(2'd1, rv); check("R2 head", rv, ptr_exp(BASE, exp_head));
            check("R3 irq", 32'(irq), 32'd1);
        end
        rd(2'd3, rv); check("R3 status", rv, 32'd1);

        // R9 post into a full queue
        @(negedge clk); port_wr = 1'b1; port_data = 32'h5555_0000;
        @(negedge clk); port_wr = 1'b0;
        check("R9 no mem write", 32'(mem_valid), 32'd0);
        rd(2'd1, rv); check("R9 head kept", rv, ptr_exp(BASE, 7));
        rd(2'd3, rv); check("R9 overflow bit", rv, 32'd3);

        // R4 write-one-to-clear
        wr(2'd3, 32'd0); rd(2'd3, rv); check("R4 zero no effect", rv, 32'd3);
        wr(2'd3, 32'd2); rd(2'd3, rv); check("R4 clear ovf", rv, 32'd1);
        wr(2'd3, 32'd1); rd(2'd3, rv); check("R4 clear post", rv, 32'd0);
        check("R4 irq low", 32'(irq), 32'd0);

        // R5 tail untouched so far, then set by software
        rd(2'd2, rv); check("R5 tail unchanged", rv, ptr_exp(BASE, 0));
        wr(2'd2, 32'hFFF0_0013);
        rd(2'd2, rv); check("R5 R6 tail write", rv, ptr_exp(BASE, 4));

        // R8 wrap: slot 7 then back to 0
        post(32'h7777_7770, 0, BASE);
        rd(2'd1, rv); check("R8 wrap head", rv, ptr_exp(BASE, 0));
        check("R3 irq after post", 32'(irq), 32'd1);
        post(32'h8888_8880, 0, BASE);
        check("R8 addr after wrap", 32'(exp_head), 32'd1);

        // R3 irq drops when tail catches head
        wr(2'd2, 32'h0000_0004);
        check("R3 irq head==tail", 32'(irq), 32'd0);
        rd(2'd3, rv); check("R3 status still set", rv, 32'd1);

        // R10 a second port write during a stall is ignored
        @(negedge clk); port_wr = 1'b1; port_data = 32'h1111_1110;
        @(negedge clk); port_data = 32'h2222_2220;
        @(negedge clk); port_wr = 1'b0;
        check("R10 data kept", mem_data, 32'h1111_1110);
        mem_ready = 1'b1;
        @(negedge clk); mem_ready = 1'b0;
        @(negedge clk);
        check("R10 no second store", 32'(mem_valid), 32'd0);
        rd(2'd1, rv); check("R10 single advance", rv, ptr_exp(BASE, 2));

        // R7 reset clears everything again
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        rd(2'd1, rv); check("R7 head after reset", rv, 32'd0);
        rd(2'd2, rv); check("R7 tail after reset", rv, 32'd0);
        rd(2'd3, rv); check("R7 status after reset", rv, 32'd0);
        check("R7 irq after reset", 32'(irq), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule